// File: doc/BRIEF.md
# Write-Through Data Cache with Store Buffer

This block is a direct-mapped data cache that always writes through. By default it holds 64 KB as 4096 lines of four 32-bit words, and each line has one valid bit. A processor sends one request per cycle, either a read or a store, and holds it steady until `cpu_ready` is high. A read that hits returns its word in the same cycle. A read that misses fetches the whole line from the next memory level, one word per beat, and then completes as a hit.

Every store is placed in a four-entry FIFO. The FIFO drains on its own, one word per handshake, into the next memory level. A store that hits a cached line also updates the addressed word in the cache. A store that misses does not allocate a line. The processor waits on a store only when the FIFO is full.

Before a read miss starts its refill, it waits until the FIFO holds no store to the same line. A refill therefore never returns data that is older than a store already accepted.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid, the store FIFO is empty, `mem_wr_valid` and `mem_rd_req` are low, and the first read of any address misses.
- R2: Address bits [31:16] are the tag, bits [15:4] the line index and bits [3:2] the word within the line. Two addresses with the same index and different tags evict each other.
- R3: When a read hits (the line is valid and its stored tag equals the address tag), `cpu_ready` is high in the same cycle and `cpu_rdata` carries the word chosen by bits [3:2].
- R4: A read miss raises `mem_rd_req` for exactly one cycle with a line-aligned `mem_rd_addr` (bits [3:0] zero). It then accepts four `mem_rd_valid` beats carrying words 0, 1, 2 and 3 in that order, with any latency before the first beat. `cpu_ready` stays low until the cycle after the last beat, when the read completes as a hit. With an empty FIFO and the first beat LAT cycles after the request, the read stalls for LAT+5 cycles.
- R5: A read, whether it hits or misses, never places a write on the memory write channel.
- R6: Each accepted store enters the FIFO with its word address and data. Stores leave in the order they were accepted, one per cycle in which `mem_wr_valid` and `mem_wr_ready` are both high. A waiting entry holds its address and data stable until it is taken.
- R7: A store that hits changes only the addressed word of the line. A store that misses allocates no line, so a later read of that address still misses.
- R8: The FIFO holds four stores. A store is accepted in the cycle it is presented while the FIFO has room. When the FIFO is full, `cpu_ready` stays low until an entry has drained.
- R9: A read miss does not request its refill while any buffered store targets the same line. A read therefore always returns the most recent value stored to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | 32 | Read data, valid when a read completes |
| mem_rd_req | output | 1 | One-cycle line refill request |
| mem_rd_addr | output | 32 | Line-aligned refill address |
| mem_rd_valid | input | 1 | Refill beat valid |
| mem_rd_data | input | 32 | Refill beat data, word 0 first |
| mem_wr_valid | output | 1 | Oldest buffered store is offered |
| mem_wr_ready | input | 1 | Memory accepts the offered store |
| mem_wr_addr | output | 32 | Word address of the offered store |
| mem_wr_data | output | 32 | Data of the offered store |

## Verification
Three latencies apply. A read hit, or a store while the FIFO has room, completes in the same cycle it is presented. The bench drives every request on a falling edge and samples `cpu_ready` and `cpu_rdata` 5 ns later, before the rising edge that would accept the request. A read miss with an empty FIFO stalls for LAT+5 cycles, where LAT is the delay the bench memory inserts before the first beat. The bench counts the stalled cycles and compares the count with that exact figure in a directed case. Where the stall length depends on how fast the memory drains the FIFO, only its lower bound is checked. Memory-side handshakes are decided and recorded on the falling edge before the rising edge that completes them. Each drained store is compared in order against the list of accepted stores, and each refill request is checked against the stores still pending.

// File: rtl/wt_dcache.sv
`timescale 1ns/1ps
module wt_dcache #(
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 12,
  parameter int WORDS   = 4,
  parameter int WB_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_ready,
  output logic [31:0] cpu_rdata,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        mem_wr_valid,
  input  logic        mem_wr_ready,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data
);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int OFF_W  = WSEL_W + 2;
  localparam int TAG_W  = 32 - INDEX_W - OFF_W;
  localparam int LINE_W = WORDS * DATA_W;
  localparam int LINES  = 1 << INDEX_W;
  localparam int PTR_W  = $clog2(WB_DEPTH);
  localparam int CNT_W  = PTR_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL} state_t;
  state_t state_q;

  logic [LINE_W-1:0] data_q [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;

  wire [TAG_W-1:0]   a_tag  = cpu_addr[31 -: TAG_W];
  wire [INDEX_W-1:0] a_idx  = cpu_addr[OFF_W +: INDEX_W];
  wire [WSEL_W-1:0]  a_wsel = cpu_addr[2 +: WSEL_W];

  wire hit = valid_q[a_idx] && (tag_q[a_idx] == a_tag);
  logic [LINE_W-1:0] rd_line;
  assign rd_line   = data_q[a_idx];
  assign cpu_rdata = rd_line[a_wsel*DATA_W +: DATA_W];

  logic [31:0]         wb_addr [WB_DEPTH];
  logic [DATA_W-1:0]   wb_data [WB_DEPTH];
  logic [WB_DEPTH-1:0] wb_v;
  logic [PTR_W-1:0]    wr_ptr, rd_ptr;
  logic [CNT_W-1:0]    cnt;
  logic [WB_DEPTH-1:0] match;

  for (genvar g = 0; g < WB_DEPTH; g++) begin : g_match
    assign match[g] = wb_v[g] && (wb_addr[g][31:OFF_W] == cpu_addr[31:OFF_W]);
  end

  wire full     = (cnt == CNT_W'(WB_DEPTH));
  wire conflict = |match;
  wire idle     = (state_q == S_IDLE);
  wire push     = idle && cpu_req && cpu_we && !full;
  wire rd_go    = idle && cpu_req && !cpu_we && !hit && !conflict;
  wire pop      = mem_wr_valid && mem_wr_ready;

  assign cpu_ready    = idle && (cpu_we ? !full : hit);
  assign mem_wr_valid = wb_v[rd_ptr];
  assign mem_wr_addr  = wb_addr[rd_ptr];
  assign mem_wr_data  = wb_data[rd_ptr];

  logic [INDEX_W-1:0] fill_idx;
  logic [TAG_W-1:0]   fill_tag;
  logic [WSEL_W-1:0]  beat;
  logic [LINE_W-1:0]  fill_buf, fill_next;
  wire last_beat = (state_q == S_FILL) && mem_rd_valid && (beat == WSEL_W'(WORDS - 1));

  assign mem_rd_req  = (state_q == S_REQ);
  assign mem_rd_addr = {fill_tag, fill_idx, {OFF_W{1'b0}}};

  always_comb begin
    fill_next = fill_buf;
    fill_next[beat*DATA_W +: DATA_W] = mem_rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      valid_q  <= '0;
      fill_idx <= '0;
      fill_tag <= '0;
      beat     <= '0;
      fill_buf <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (rd_go) begin
          fill_idx <= a_idx;
          fill_tag <= a_tag;
          beat     <= '0;
          state_q  <= S_REQ;
        end
        S_REQ: state_q <= S_FILL;
        S_FILL: if (mem_rd_valid) begin
          fill_buf <= fill_next;
          beat     <= beat + 1'b1;
          if (last_beat) begin
            valid_q[fill_idx] <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (last_beat) begin
      data_q[fill_idx] <= fill_next;
      tag_q[fill_idx]  <= fill_tag;
    end else if (push && hit) begin
      data_q[a_idx][a_wsel*DATA_W +: DATA_W] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_v   <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) begin
        wb_v[wr_ptr] <= 1'b1;
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (pop) begin
        wb_v[rd_ptr] <= 1'b0;
        rd_ptr <= rd_ptr + 1'b1;
      end
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      wb_addr[wr_ptr] <= {cpu_addr[31:2], 2'b00};
      wb_data[wr_ptr] <= cpu_wdata;
    end
  end
endmodule

// File: rtl/wt_dcache_chk.sv
`timescale 1ns/1ps
module wt_dcache_chk #(
  parameter int OFF_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_ready,
  input logic        mem_rd_req,
  input logic [31:0] mem_rd_addr,
  input logic        mem_wr_valid,
  input logic        mem_wr_ready,
  input logic [31:0] mem_wr_addr,
  input logic [31:0] mem_wr_data
);
  assert_fill_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);

  assert_fill_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !cpu_ready);

  assert_read_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && !mem_wr_valid) |=> !mem_wr_valid);

  assert_wr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  assert_no_stale_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !(mem_wr_valid && mem_wr_addr[31:OFF_W] == mem_rd_addr[31:OFF_W]));
endmodule

bind wt_dcache wt_dcache_chk #(.OFF_W(OFF_W)) i_chk (.*);

// File: tb/test_wt_dcache.sv
`timescale 1ns/1ps
module test_wt_dcache;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr, mem_wr_data;

  wt_dcache i_wt_dcache (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit hold_wr = 1'b0;
  logic [63:0] wq[$];
  logic [31:0] mem_m[int unsigned];
  logic [31:0] arch[int unsigned];
  bit          cv[int unsigned];
  logic [15:0] ct[int unsigned];
  bit rd_active = 0;
  int rd_wait = 0, rd_beat = 0;
  logic [31:0] rd_base;

  function automatic logic [31:0] init_val(input logic [31:0] a);
    return a ^ 32'h5A5A_1234;
  endfunction
  function automatic logic [31:0] mem_get(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : init_val(a);
  endfunction
  function automatic logic [31:0] arch_get(input logic [31:0] a);
    return arch.exists(a) ? arch[a] : init_val(a);
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_wr_ready = hold_wr ? 1'b0 : ($urandom % 4 != 0);
    if (rst_n && mem_wr_valid && mem_wr_ready) begin
      if (wq.size() == 0) chk(0, "R5 unexpected memory write", mem_wr_addr, 32'h0);
      else begin
        chk(mem_wr_addr == wq[0][63:32], "R6 drain address order", mem_wr_addr, wq[0][63:32]);
        chk(mem_wr_data == wq[0][31:0], "R6 drain data order", mem_wr_data, wq[0][31:0]);
        void'(wq.pop_front());
      end
      mem_m[mem_wr_addr] = mem_wr_data;
    end
    mem_rd_valid = 1'b0;
    if (rd_active) begin
      if (rd_wait > 0) rd_wait--;
      if (rd_wait == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem_get(rd_base + 32'(rd_beat * 4));
        rd_beat++;
        if (rd_beat == 4) rd_active = 0;
      end
    end
    if (rst_n && mem_rd_req) begin
      bit pend = 0;
      foreach (wq[i]) if (wq[i][63:36] == mem_rd_addr[31:4]) pend = 1;
      chk(!pend, "R9 refill while same line buffered", mem_rd_addr, 32'h0);
      chk(mem_rd_addr[3:0] == 4'h0, "R4 refill line aligned", mem_rd_addr, {mem_rd_addr[31:4], 4'h0});
      rd_active = 1; rd_wait = LAT; rd_beat = 0; rd_base = mem_rd_addr;
    end
  end

  task automatic acc(input bit we, input logic [31:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int stall);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; stall = 0; rd = '0;
    forever begin
      #5;
      if (cpu_ready) begin
        rd = cpu_rdata;
        if (we) begin
          wq.push_back({a, d});
          arch[a] = d;
        end
        break;
      end
      @(negedge clk);
      stall++;
      if (stall > 2000) break;
    end
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic rd_check(input logic [31:0] a, input string rq);
    logic [31:0] r; int s;
    int unsigned idx = 32'(a[15:4]);
    bit exp_hit = cv.exists(idx) && cv[idx] && ct[idx] == a[31:16];
    acc(0, a, '0, r, s);
    chk((s == 0) == exp_hit, {rq, " hit/miss"}, 32'(s), exp_hit ? 32'd0 : 32'd1);
    chk(r == arch_get(a), {rq, " read data"}, r, arch_get(a));
    cv[idx] = 1; ct[idx] = a[31:16];
  endtask

  task automatic drain();
    for (int k = 0; k < 400 && wq.size() != 0; k++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000000;
    fails++; tests++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r; int s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_wr_valid, "R1 buffer empty after reset", 32'(mem_wr_valid), 32'h0);
    chk(!mem_rd_req, "R1 no refill after reset", 32'(mem_rd_req), 32'h0);

    // R1 / R4: first read misses, exact stall with empty buffer
    acc(0, 32'h0001_0044, '0, r, s);
    chk(s == LAT + 5, "R4 miss stall cycles (R1 cold miss)", 32'(s), 32'(LAT + 5));
    chk(r == arch_get(32'h0001_0044), "R4 refill word", r, arch_get(32'h0001_0044));
    cv[32'h004] = 1; ct[32'h004] = 16'h0001;
    rd_check(32'h0001_0040, "R3 same-line word0");
    rd_check(32'h0001_004C, "R3 same-line word3");

    // R2 aliasing
    rd_check(32'h0002_0044, "R2 alias other tag");
    rd_check(32'h0001_0048, "R2 original evicted");

    // R7 write hit updates only one word
    acc(1, 32'h0001_0048, 32'hCAFE_0001, r, s);
    rd_check(32'h0001_0048, "R7 write hit word");
    rd_check(32'h0001_0044, "R7 neighbour unchanged");
    // R7 write miss does not allocate
    acc(1, 32'h0009_0204, 32'hBEEF_0002, r, s);
    drain();
    rd_check(32'h0009_0204, "R7 no allocate");

    // R8 full buffer stalls
    drain();
    hold_wr = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      acc(1, 32'h0003_0300 + 32'(k * 16), 32'h1000 + 32'(k), r, s);
      chk(s == 0, "R8 store accepted with room", 32'(s), 32'h0);
    end
    fork
      acc(1, 32'h0003_0400, 32'h2222, r, s);
      begin repeat (6) @(negedge clk); hold_wr = 1'b0; end
    join
    chk(s >= 5, "R8 store stalls when full", 32'(s), 32'd5);
    drain();

    // R9 read waits for buffered store to same line
    hold_wr = 1'b1;
    @(negedge clk);
    acc(1, 32'h0007_0508, 32'h7777_ABCD, r, s);
    fork
      acc(0, 32'h0007_0508, '0, r, s);
      begin repeat (8) @(negedge clk); hold_wr = 1'b0; end
    join
    chk(s >= 8, "R9 read held behind store", 32'(s), 32'd8);
    chk(r == 32'h7777_ABCD, "R9 read sees latest store", r, 32'h7777_ABCD);
    cv[32'h050] = 1; ct[32'h050] = 16'h0007;

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      logic [15:0] tg = 16'(($urandom % 4) * 16'h1111);
      logic [11:0] ix = ($urandom % 5 == 4) ? 12'hFFF : 12'($urandom % 4);
      a = {tg, ix, 2'($urandom % 4), 2'b00};
      if ($urandom % 2) acc(1, a, $urandom, r, s);
      else rd_check(a, "R3 random read");
    end
    drain();
    chk(wq.size() == 0, "R6 all stores drained", 32'(wq.size()), 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule